// File: doc/BRIEF.md
# Broadside Read Bridge

This block lets a processor core fetch a block of 4, 32 or 64 bytes from memory without stalling on the bus. The core stores a command as one 8-byte broadside store. The low word holds the configuration and the high word holds the byte address. The bridge puts one request on a valid/ready memory read master. It keeps the returned bytes in a holding register until the core collects them with a broadside load that fills its register file from R2 upward. A 32-byte read therefore lands in R2..R9.

A four-bit status word tells the core where the transfer stands. Software polls it and may collect only once the data-full bit is set. A collect made too early does not wedge the bridge. It returns zeros and raises a sticky underrun flag.

In auto mode, each collect starts the next sequential read at once. The next address is the old one plus the read size. Auto mode keeps running until reset.

Top module: `rbr_read_bridge`

## Requirements
- R1: After a synchronous active-low reset, the status is 0x0, `mreq_valid` is low, `rd_data` is all zero and `rd_underrun` is low.
- R2: Status bit 0 is busy, bit 1 is command held, bit 2 is data full and bit 3 is bus request pending. Status only ever takes the values 0x0, 0xB, 0x8 and 0x5.
- R3: When the status is 0x0, a store with a legal size code (config bits [2:1] of 0, 2 or 3) is accepted. From the next cycle the status is 0xB and `mreq_valid` is high. `mreq_addr` equals the stored address and `mreq_size` equals the size code.
- R4: A store whose size code is 1 is ignored, and the status stays 0x0.
- R5: A store made while the status is not 0x0 is ignored, and the outstanding request keeps its address and size.
- R6: While `mreq_valid` is high and `mreq_ready` is low, the request and its address stay unchanged. The cycle after a valid/ready handshake, the status is 0x8 and `mreq_valid` is low.
- R7: A response (`mrsp_valid`) while the status is 0x8 moves the status to 0x5 on the next cycle. A response in any other state is ignored. Data byte k is bits [8k+7:8k]. Only the first 4, 32 or 64 bytes (codes 0, 2, 3) are kept, and the higher bytes read as zero.
- R8: `rd_data` is all zero whenever the status is not 0x5.
- R9: With the auto bit (config bit 0) clear, a collect while the status is 0x5 returns the status to 0x0 on the next cycle.
- R10: With the auto bit set, a collect while the status is 0x5 gives status 0xB on the next cycle. The size is unchanged, and `mreq_addr` is advanced by 4, 32 or 64 bytes.
- R11: A collect while the status is not 0x5 sets `rd_underrun` on the next cycle and leaves the status unchanged. `rd_underrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Broadside command store strobe |
| cmd_cfg | input | 32 | Configuration word: bit 0 auto, bits [2:1] size code |
| cmd_addr | input | ADDR_W | Byte address of the read |
| collect | input | 1 | Broadside data load strobe |
| rd_data | output | DATA_W | Held read data, byte k at bits [8k+7:8k] |
| rd_status | output | 4 | Status word |
| rd_underrun | output | 1 | Sticky premature-collect flag |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory read request accepted |
| mreq_addr | output | ADDR_W | Request byte address |
| mreq_size | output | 2 | Request size code |
| mrsp_valid | input | 1 | Read response valid, single beat |
| mrsp_data | input | DATA_W | Read response data |

## Verification
The hardest states to reach are those where an input arrives in the wrong phase of the fixed 0xB, 0x8, 0x5 walk. Examples are a second store while a request is stalled on `mreq_ready`, a stray response before the handshake, and a collect in idle. The bench's memory responder holds `mreq_ready` low and delays its response for chosen numbers of cycles. This opens windows in which those inputs are injected on purpose. A behavioural model is compared on every clock and catches any state or data the stray inputs disturb.

// File: rtl/rbr_pkg.sv
// Package: shared status encoding and size decoding for the read bridge.
// Assumes the widest read is 64 bytes.
package rbr_pkg;
    localparam int RBR_CNT_W = 7;

    // Each state value is the status word that software sees.
    typedef enum logic [3:0] {
        ST_IDLE = 4'h0,
        ST_REQ  = 4'hB,
        ST_WAIT = 4'h8,
        ST_FULL = 4'h5
    } rbr_state_e;

    localparam logic [1:0] SZ_4  = 2'd0;
    localparam logic [1:0] SZ_BAD = 2'd1;
    localparam logic [1:0] SZ_32 = 2'd2;
    localparam logic [1:0] SZ_64 = 2'd3;

    // Byte count for a size code; the illegal code yields zero.
    function automatic logic [RBR_CNT_W-1:0] rbr_bytes(input logic [1:0] code);
        case (code)
            SZ_4:    return 7'd4;
            SZ_32:   return 7'd32;
            SZ_64:   return 7'd64;
            default: return 7'd0;
        endcase
    endfunction
endpackage

// File: rtl/rbr_cmd_decode.sv
// Splits the broadside configuration word into auto enable and size code.
// Assumes the word is only meaningful in the cycle cmd_we is high.
module rbr_cmd_decode #(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] cfg,
    output logic             auto_en,
    output logic [1:0]       size_code,
    output logic             legal
);
    import rbr_pkg::*;

    logic unused_cfg_bits;

    // Field extraction: bit 0 auto, bits [2:1] size; other bits are reserved.
    always_comb begin
        auto_en         = cfg[0];
        size_code       = cfg[2:1];
        legal           = (cfg[2:1] != SZ_BAD);
        unused_cfg_bits = ^cfg[CFG_W-1:3];
    end
endmodule

// File: rtl/rbr_fetch_ctrl.sv
// Sequencer: accepts a command in idle, drives one memory request, waits
// for its response, then waits for the core to collect. Auto mode re-arms
// at the next address. Assumes one outstanding read and a single-beat
// response.
module rbr_fetch_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              cmd_legal,
    input  logic              cmd_auto,
    input  logic [1:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              collect,
    input  logic              mreq_ready,
    input  logic              mrsp_valid,
    output rbr_pkg::rbr_state_e state,
    output logic              mreq_valid,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [1:0]        code_q,
    output logic              capture,
    output logic              underrun
);
    import rbr_pkg::*;

    rbr_state_e        state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              auto_q, auto_d;
    logic [1:0]        code_d;
    logic              underrun_q;
    logic [ADDR_W-1:0] step;

    assign step = ADDR_W'(rbr_bytes(code_q));

    // Next-state and command latch decision.
    always_comb begin
        state_d = state;
        addr_d  = addr_q;
        code_d  = code_q;
        auto_d  = auto_q;
        case (state)
            ST_IDLE: if (cmd_we && cmd_legal) begin
                state_d = ST_REQ;
                addr_d  = cmd_addr;
                code_d  = cmd_code;
                auto_d  = cmd_auto;
            end
            ST_REQ:  if (mreq_ready) state_d = ST_WAIT;
            ST_WAIT: if (mrsp_valid) state_d = ST_FULL;
            ST_FULL: if (collect) begin
                if (auto_q) begin
                    state_d = ST_REQ;
                    addr_d  = addr_q + step;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            code_q <= SZ_4;
            auto_q <= 1'b0;
        end else begin
            state  <= state_d;
            addr_q <= addr_d;
            code_q <= code_d;
            auto_q <= auto_d;
        end
    end

    // Sticky flag for a collect made before data is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                           underrun_q <= 1'b0;
        else if (collect && state != ST_FULL) underrun_q <= 1'b1;
    end

    assign mreq_valid = (state == ST_REQ);
    assign mreq_addr  = addr_q;
    assign capture    = (state == ST_WAIT) && mrsp_valid;
    assign underrun   = underrun_q;

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(code_q));
    p_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid && mreq_ready |=> state == ST_WAIT && !mreq_valid);
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && (state == ST_REQ || state == ST_WAIT) |=> $stable(addr_q) && $stable(code_q));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL && collect && !auto_q |=> state == ST_IDLE);
    p_auto_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FULL && collect && auto_q |=>
            state == ST_REQ && addr_q == $past(addr_q) + $past(step));
    p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/rbr_data_hold.sv
// Holding register for the returned bytes. Bytes beyond the read size are
// stored as zero. Data is only visible while the status says full.
// Assumes capture is a single-cycle strobe.
module rbr_data_hold #(
    parameter int MAX_BYTES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic                   full,
    input  logic [1:0]             size_code,
    input  logic [MAX_BYTES*8-1:0] rsp_data,
    output logic [MAX_BYTES*8-1:0] rd_data
);
    import rbr_pkg::*;

    logic [RBR_CNT_W-1:0] nbytes;
    logic [7:0]           hold_q [MAX_BYTES];

    assign nbytes = rbr_bytes(size_code);

    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        // Capture one byte lane, zeroing lanes above the read size.
        always_ff @(posedge clk) begin
            if (!rst_n)       hold_q[b] <= '0;
            else if (capture) hold_q[b] <= (RBR_CNT_W'(b) < nbytes) ? rsp_data[b*8 +: 8] : 8'h00;
        end
        assign rd_data[b*8 +: 8] = full ? hold_q[b] : 8'h00;
    end

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full && size_code == SZ_4 |-> rd_data[MAX_BYTES*8-1:32] == '0);
endmodule

// File: rtl/rbr_read_bridge.sv
// Top: broadside read bridge. A command store starts one memory read. The
// status walks 0xB, 0x8, 0x5. A collect returns the held data. Assumes a
// 64-byte maximum transfer (MAX_BYTES = 64).
module rbr_read_bridge #(
    parameter int ADDR_W    = 32,
    parameter int CFG_W     = 32,
    parameter int MAX_BYTES = 64,
    localparam int DATA_W   = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CFG_W-1:0]  cmd_cfg,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              collect,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        rd_status,
    output logic              rd_underrun,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [1:0]        mreq_size,
    input  logic              mrsp_valid,
    input  logic [DATA_W-1:0] mrsp_data
);
    import rbr_pkg::*;

    logic       dec_auto, dec_legal, capture;
    logic [1:0] dec_code, code_q;
    rbr_state_e state;

    rbr_cmd_decode #(.CFG_W(CFG_W)) u_dec (
        .cfg(cmd_cfg), .auto_en(dec_auto), .size_code(dec_code), .legal(dec_legal)
    );

    rbr_fetch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_legal(dec_legal),
        .cmd_auto(dec_auto), .cmd_code(dec_code), .cmd_addr(cmd_addr),
        .collect(collect), .mreq_ready(mreq_ready), .mrsp_valid(mrsp_valid),
        .state(state), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
        .code_q(code_q), .capture(capture), .underrun(rd_underrun)
    );

    rbr_data_hold #(.MAX_BYTES(MAX_BYTES)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(capture), .full(state == ST_FULL),
        .size_code(code_q), .rsp_data(mrsp_data), .rd_data(rd_data)
    );

    assign rd_status = state;
    assign mreq_size = code_q;

    p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status == 4'h0 || rd_status == 4'hB || rd_status == 4'h8 || rd_status == 4'h5);
    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status == 4'h0 && cmd_we && dec_legal |=> rd_status == 4'hB && mreq_addr == $past(cmd_addr));
endmodule

// File: tb/tb_rbr_read_bridge.sv
module tb_rbr_read_bridge;
    localparam int AW = 32;
    localparam int DW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_cfg = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          collect = 1'b0;
    logic [DW-1:0] rd_data;
    logic [3:0]    rd_status;
    logic          rd_underrun;
    logic          mreq_valid;
    logic          mreq_ready = 1'b0;
    logic [AW-1:0] mreq_addr;
    logic [1:0]    mreq_size;
    logic          mrsp_valid = 1'b0;
    logic [DW-1:0] mrsp_data = '0;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rbr_read_bridge dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_cfg(cmd_cfg), .cmd_addr(cmd_addr),
        .collect(collect), .rd_data(rd_data), .rd_status(rd_status), .rd_underrun(rd_underrun),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
        .mreq_size(mreq_size), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
    );

    function automatic int nb(logic [1:0] c);
        return (c == 0) ? 4 : (c == 2) ? 32 : (c == 3) ? 64 : 0;
    endfunction

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
        logic [DW-1:0] r;
        for (int k = 0; k < 64; k++) r[k*8 +: 8] = (a[7:0] + 8'(k)) ^ 8'h5A;
        return r;
    endfunction

    function automatic logic [DW-1:0] trim(logic [DW-1:0] d, int n);
        logic [DW-1:0] r = '0;
        for (int k = 0; k < n; k++) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int            m_st = 0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0]    m_code = '0;
    bit            m_auto = 0;
    bit            m_under = 0;
    logic [DW-1:0] m_data = '0;
    bit            m_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = '0; m_code = '0; m_auto = 0; m_under = 0; m_data = '0;
            m_on = 1;
        end else begin
            if (collect && m_st != 5) m_under = 1;
            case (m_st)
                0:  if (cmd_we && cmd_cfg[2:1] != 2'd1) begin
                        m_st = 'hB; m_addr = cmd_addr; m_code = cmd_cfg[2:1]; m_auto = cmd_cfg[0];
                    end
                'hB: if (mreq_ready) m_st = 8;
                8:  if (mrsp_valid) begin m_st = 5; m_data = trim(mrsp_data, nb(m_code)); end
                5:  if (collect) begin
                        if (m_auto) begin m_st = 'hB; m_addr = m_addr + AW'(nb(m_code)); end
                        else m_st = 0;
                    end
                default: m_st = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (m_on && !done) begin
            chk("R2 status", DW'(rd_status), DW'(m_st));
            chk("R3/R6 mreq_valid", DW'(mreq_valid), DW'(m_st == 'hB));
            if (m_st == 'hB) begin
                chk("R3/R5 mreq_addr", DW'(mreq_addr), DW'(m_addr));
                chk("R3/R5 mreq_size", DW'(mreq_size), DW'(m_code));
            end
            chk("R7/R8 rd_data", rd_data, (m_st == 5) ? m_data : '0);
            chk("R11 underrun", DW'(rd_underrun), DW'(m_under));
        end
    end

    task automatic issue(logic [31:0] cfg, logic [AW-1:0] a);
        cmd_cfg = cfg; cmd_addr = a; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic do_collect();
        collect = 1'b1;
        @(negedge clk);
        collect = 1'b0;
    endtask

    // Memory responder with chosen ready and response delays.
    task automatic serve(int rdly, int sdly);
        logic [AW-1:0] a;
        while (!mreq_valid) @(negedge clk);
        a = mreq_addr;
        repeat (rdly) @(negedge clk);
        mreq_ready = 1'b1;
        @(negedge clk);
        mreq_ready = 1'b0;
        chk("R6 status after handshake", DW'(rd_status), DW'(4'h8));
        repeat (sdly) @(negedge clk);
        mrsp_data = pat(a); mrsp_valid = 1'b1;
        @(negedge clk);
        mrsp_valid = 1'b0;
        chk("R7 status after response", DW'(rd_status), DW'(4'h5));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset status", DW'(rd_status), '0);
        chk("R1 reset data", rd_data, '0);
        chk("R1 reset underrun", DW'(rd_underrun), '0);

        // 4-byte read
        issue(32'h0, 32'h1000);
        chk("R3 status 0xB", DW'(rd_status), DW'(4'hB));
        serve(2, 3);
        chk("R7 4-byte data", rd_data, trim(pat(32'h1000), 4));
        do_collect();
        chk("R9 back to idle", DW'(rd_status), '0);

        // 32-byte read with a stray response and a busy store
        issue(32'h4, 32'h0100);
        mrsp_data = '1; mrsp_valid = 1'b1;
        @(negedge clk);
        mrsp_valid = 1'b0;
        chk("R7 stray response ignored", DW'(rd_status), DW'(4'hB));
        issue(32'h6, 32'h0900);
        chk("R5 busy store addr kept", DW'(mreq_addr), DW'(32'h0100));
        chk("R5 busy store size kept", DW'(mreq_size), DW'(2'd2));
        serve(4, 1);
        chk("R7 32-byte data", rd_data, trim(pat(32'h0100), 32));
        do_collect();

        // Illegal size code
        issue(32'h2, 32'h2000);
        chk("R4 code 1 ignored", DW'(rd_status), '0);

        // Premature collect
        do_collect();
        chk("R11 underrun set", DW'(rd_underrun), DW'(1'b1));
        chk("R11 status unchanged", DW'(rd_status), '0);

        // 64-byte read
        issue(32'h6, 32'h3000);
        serve(0, 0);
        chk("R7 64-byte data", rd_data, pat(32'h3000));
        do_collect();

        // Auto mode, 64-byte steps
        issue(32'h7, 32'h4000);
        serve(1, 2);
        do_collect();
        chk("R10 auto rearm", DW'(rd_status), DW'(4'hB));
        chk("R10 auto address", DW'(mreq_addr), DW'(32'h4040));
        serve(0, 1);
        chk("R10 auto data", rd_data, pat(32'h4040));
        chk("R11 underrun still set", DW'(rd_underrun), DW'(1'b1));

        // Auto mode, 4-byte steps
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears auto run", DW'(rd_status), '0);
        chk("R1 reset clears underrun", DW'(rd_underrun), '0);
        issue(32'h1, 32'h5000);
        serve(0, 0);
        do_collect();
        chk("R10 4-byte step", DW'(mreq_addr), DW'(32'h5004));
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule